// File: doc/BRIEF.md
# Seconds Watchdog with Reset Pulse

The block is a watchdog that software arms and feeds through a single control byte. The byte holds a run bit, a read-only expiry flag and a six-bit timeout length in seconds. A prescaler divides the reference clock down to a one-second tick. While the watchdog runs, each tick takes one second off the remaining time. Software feeds the watchdog by writing the byte again with the run bit set, which reloads the countdown. Writing the byte with the run bit clear stops the watchdog.

If the countdown runs out, the block sets the expiry flag and requests one active-low reset pulse of fixed length. The reset pin is open drain, and the pin can be shared with another function. For this reason the low drive is given as an output enable. That enable is only asserted when the pin has been assigned to the reset role through `rst_pin_en_i`. The flag stays set until the next register write.

Top module: `wdt_reset_pulser`

## Requirements
- R1: After reset, the read byte is 0x00, `timeout_o` is 0 and `rst_drive_low_o` is 0.
- R2: The read byte carries the run bit in bit 7, the expiry flag in bit 6 and the programmed seconds value in bits 5:0.
- R3: A write never changes bit 6 directly. The value written to bit 6 is ignored.
- R4: A write with bit 7 set and a seconds value N in the range 1 to 63 sets the expiry flag exactly N*TICK_DIV cycles after the write edge, unless another write comes first.
- R5: A write with bit 7 set and N = 0 expires after one tick, which is TICK_DIV cycles.
- R6: A write while the watchdog is running reloads the countdown and restarts the one-second prescaler. Expiry is then timed from the latest write.
- R7: A write with bit 7 clear stops the countdown, so no expiry follows. It also clears the expiry flag.
- R8: Each expiry drives `rst_drive_low_o` high for exactly PULSE_CYC cycles. The pulse starts in the same cycle as the expiry flag. Only one pulse is produced per expiry.
- R9: The expiry flag stays set until the next write.
- R10: While `rst_pin_en_i` is 0, `rst_drive_low_o` stays 0. The expiry flag still sets as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Write data: run bit, ignored bit, seconds value |
| rd_data_o | output | 8 | Read port for the control byte |
| timeout_o | output | 1 | Expiry flag |
| rst_pin_en_i | input | 1 | 1 when the shared pin is assigned to the reset role |
| rst_drive_low_o | output | 1 | Open-drain enable: 1 pulls the reset pin low |

## Verification
The bench builds the block with TICK_DIV = 10 and PULSE_CYC = 5. With these values one second lasts ten cycles, and the longest timeout of 63 seconds fits within a few hundred cycles. The exact cycle of every flag edge and pulse edge can therefore be predicted and compared. A short second also puts a feed write well inside one countdown interval. This shows whether the prescaler restarts on the write, because a prescaler that keeps its phase would expire six cycles early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SECS_W = 6;

  typedef struct packed {
    logic              run;
    logic              flag;
    logic [SECS_W-1:0] secs;
  } wdt_ctrl_t;

  localparam int RUN_BIT  = 7;
  localparam int FLAG_BIT = 6;
endpackage

// File: rtl/wdt_sec_prescaler.sv
module wdt_sec_prescaler #(
  parameter int TICK_DIV = 14318180
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !run_i)  cnt_q <= '0;
    else if (cnt_q == LAST)        cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && !restart_i && (cnt_q == LAST);

  generate
    if (TICK_DIV > 1) begin : g_tick_chk
      AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o); // R4
    end
  endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_run_i,
  input  logic [SECS_W-1:0] wr_secs_i,
  input  logic              tick_i,
  output logic              counting_o,
  output wdt_ctrl_t         ctrl_o,
  output logic              expire_o
);
  wdt_ctrl_t         ctrl_q;
  logic [SECS_W-1:0] remain_q;
  logic              last_sec;

  assign counting_o = ctrl_q.run && !ctrl_q.flag;
  // 0 or 1 left: the next tick ends the countdown
  assign last_sec   = (remain_q <= SECS_W'(1));
  assign expire_o   = tick_i && counting_o && last_sec && !wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      remain_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.run  <= wr_run_i;
      ctrl_q.flag <= 1'b0;
      ctrl_q.secs <= wr_secs_i;
      remain_q    <= wr_secs_i;
    end else if (tick_i && counting_o) begin
      if (last_sec) ctrl_q.flag <= 1'b1;
      else          remain_q    <= remain_q - 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_FLAG_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.flag) |-> $past(tick_i)); // R4
  AST_WRITE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !ctrl_q.flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag && !wr_en_i) |=> ctrl_q.flag); // R9
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_CYC = 57273
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYC);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (fire_i)      cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  AST_PULSE_FROM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(fire_i)); // R8
endmodule

// File: rtl/wdt_reset_pulser.sv
module wdt_reset_pulser
  import wdt_pkg::*;
#(
  parameter int TICK_DIV  = 14318180,
  parameter int PULSE_CYC = 57273
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       timeout_o,
  input  logic       rst_pin_en_i,
  output logic       rst_drive_low_o
);
  logic      tick, counting, expire, pulse_active;
  wdt_ctrl_t ctrl;
  logic      unused_flag_wr;

  assign unused_flag_wr = wr_data_i[FLAG_BIT];

  wdt_sec_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (counting),
    .restart_i (wr_en_i),
    .tick_o    (tick)
  );

  wdt_countdown u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_run_i   (wr_data_i[RUN_BIT]),
    .wr_secs_i  (wr_data_i[SECS_W-1:0]),
    .tick_i     (tick),
    .counting_o (counting),
    .ctrl_o     (ctrl),
    .expire_o   (expire)
  );

  wdt_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (expire),
    .active_o (pulse_active)
  );

  assign rd_data_o       = ctrl;
  assign timeout_o       = ctrl.flag;
  assign rst_drive_low_o = pulse_active && rst_pin_en_i;

  AST_FLAG_FALL_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> $past(wr_en_i)); // R9
  AST_PULSE_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_active) |-> timeout_o); // R8
endmodule

// File: tb/wdt_reset_pulser_bench.sv
module wdt_reset_pulser_bench;
  localparam int TD = 10;
  localparam int PC = 5;
  localparam int EV_TO = 0, EV_RISE = 1, EV_FALL = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       to_flag;
  logic       pin_en = 1'b1;
  logic       drv_low;

  wdt_reset_pulser #(.TICK_DIV(TD), .PULSE_CYC(PC)) u_wdt_reset_pulser (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .timeout_o(to_flag), .rst_pin_en_i(pin_en),
    .rst_drive_low_o(drv_low)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int kind; int at; string req; } ev_t;
  ev_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit mon_on = 1'b0, prev_to = 1'b0, prev_dl = 1'b0;

  task automatic expect_ev(int kind, int at, string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic got(int kind);
    ev_t e;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual kind %0d at %0d, expected none", kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d at %0d, expected kind %0d at %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  // monitor: edges of the flag and the pin drive
  always @(negedge clk) if (mon_on) begin
    if (to_flag && !prev_to) got(EV_TO);
    if (drv_low && !prev_dl) got(EV_RISE);
    if (!drv_low && prev_dl) got(EV_FALL);
    prev_to = to_flag;
    prev_dl = drv_low;
  end

  task automatic do_write(input logic [7:0] d, output int at);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    #1 at = cyc;
    wr_en = 1'b0;
  endtask

  task automatic check_rd(input logic [7:0] exp_v, input string req);
    @(negedge clk);
    n_cmp++;
    if (rd_data !== exp_v) begin
      n_bad++;
      $display("FAIL %s: read actual %02h expected %02h", req, rd_data, exp_v);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp_v, input string req);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp_v);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_rd(8'h00, "R1");
    check_bit(to_flag, 1'b0, "R1 flag");
    check_bit(drv_low, 1'b0, "R1 drive");
    mon_on = 1'b1;

    // R4 R8 R2: three seconds, then one pulse
    do_write(8'h83, w);
    expect_ev(EV_TO, w + 3*TD, "R4");
    expect_ev(EV_RISE, w + 3*TD, "R8 rise");
    expect_ev(EV_FALL, w + 3*TD + PC, "R8 width");
    idle(3*TD + 40);
    check_rd(8'hC3, "R2");
    // R9 flag stays set, no second pulse
    idle(50);
    check_rd(8'hC3, "R9");

    // R3 R7: bit 6 written as 1 while stopping; flag clears
    do_write(8'h45, w);
    check_rd(8'h05, "R3 R7");
    idle(80);
    check_bit(to_flag, 1'b0, "R7 stopped");

    // R6 feed: second write restarts the whole interval
    do_write(8'h82, w);
    idle(15);
    do_write(8'h82, w);
    expect_ev(EV_TO, w + 2*TD, "R6");
    expect_ev(EV_RISE, w + 2*TD, "R6 rise");
    expect_ev(EV_FALL, w + 2*TD + PC, "R6 fall");
    idle(2*TD + 20);

    // R5 zero seconds
    do_write(8'h80, w);
    expect_ev(EV_TO, w + TD, "R5");
    expect_ev(EV_RISE, w + TD, "R5 rise");
    expect_ev(EV_FALL, w + TD + PC, "R5 fall");
    idle(TD + 20);

    // R7 stop before expiry
    do_write(8'h84, w);
    idle(20);
    do_write(8'h04, w);
    idle(60);
    check_rd(8'h04, "R7 stop");

    // R10 pin not in reset role: flag only
    @(negedge clk) pin_en = 1'b0;
    do_write(8'h81, w);
    expect_ev(EV_TO, w + TD, "R10 flag");
    idle(TD + 2);
    check_bit(drv_low, 1'b0, "R10 drive");
    idle(20);
    @(negedge clk) pin_en = 1'b1;
    idle(2);
    check_bit(drv_low, 1'b0, "R10 after");

    // R4 longest count
    do_write(8'hBF, w);
    check_rd(8'hBF, "R2 run");
    expect_ev(EV_TO, w + 63*TD, "R4 max");
    expect_ev(EV_RISE, w + 63*TD, "R8 max rise");
    expect_ev(EV_FALL, w + 63*TD + PC, "R8 max fall");
    idle(63*TD + 20);
    check_rd(8'hFF, "R2 max");

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R4 missing events: actual %0d pending, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule